// File: doc/BRIEF.md
# Manchester Line Receiver with Preamble Lock

This block turns a Manchester-coded serial line into bytes. The core clock runs at sixteen times the bit rate, and every clock takes one sample of the line. The receiver waits for a line transition and treats it as the centre of a bit. A phase counter then opens a short window around each following bit centre. Transitions that fall outside that window, such as the ones at bit boundaries, are ignored. The direction of the transition inside the window gives the bit value.

The first bits after lock must match a selectable preamble pattern for a chosen number of bit periods. After that, data bits are packed into bytes, least significant bit first, until the line stops toggling. A selectable drift mode lets the receiver re-align its phase on every centre transition it captures, so it can follow a sender whose bit period is a little off. Software is expected to reset the block with a receive polarity of 1, a preamble length of 1 and the all-ones pattern. All configuration inputs are assumed to be held steady while a frame is being received.

Top module: `manch_rx`

## Requirements
- R1: With `rx_pol` at 0, a high-to-low transition at the bit centre is a data 1 and a low-to-high transition is a data 0. With `rx_pol` at 1 the meaning is swapped.
- R2: Data bits are packed least significant bit first. After the eighth bit, `data_valid` is high for exactly one clock while `data_out` holds the byte. Further bits are packed into the next byte without a new preamble.
- R3: With `pre_len` at 0 there is no preamble, and the transition that first locks the receiver is data bit 0.
- R4: With `pre_len` from 1 to 15, data is accepted only after that many consecutive matching preamble bits. The lock bit counts as preamble bit 0. Each preamble bit is checked using the polarity-0 meaning, whatever `rx_pol` is: a high-to-low transition is a 1. The `pat_sel` codes are: 00 every bit 1; 01 every bit 0; 10 alternating, starting with 0; 11 alternating, starting with 1.
- R5: A preamble bit that does not match sets the match count back to zero, so the full length is needed again.
- R6: While locked, a bit window (from WIN clocks before to WIN clocks after the expected centre, WIN = 4) may close with no transition. When it does, `code_err` pulses for one clock, any partial byte is dropped, and the receiver goes back to waiting for a lock transition. `code_err` and `data_valid` are never high together.
- R7: With `drift_en` at 0, the phase counter advances by one every clock while locked and is never re-aligned. A sender using 18-clock bits then causes `code_err` and no byte.
- R8: With `drift_en` at 1, each captured centre transition re-aligns the phase, so a frame sent with 18-clock bits is received correctly.
- R9: Transitions at bit boundaries, outside the window, are ignored. A data stream whose bits repeat, and so has boundary transitions, still decodes correctly.
- R10: After reset, `data_valid` and `code_err` are low, and a quiet line never raises either of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 times the bit rate |
| rst_n | input | 1 | Synchronous reset, active low |
| line_in | input | 1 | Raw Manchester line |
| rx_pol | input | 1 | Data polarity select |
| pat_sel | input | 2 | Preamble pattern code |
| pre_len | input | 4 | Preamble length in bits, 0 turns the preamble off |
| drift_en | input | 1 | Re-align phase on captured transitions |
| data_out | output | 8 | Last completed byte |
| data_valid | output | 1 | One-clock strobe, byte complete |
| code_err | output | 1 | One-clock strobe, bit window missed |

## Verification
The assertions check these properties on every cycle:
- a byte strobe lasts one clock and occurs only while data is being received;
- a coding error occurs only from a locked state, always leaves the receiver searching, and never coincides with a byte strobe;
- with drift mode off, the phase counter advances by exactly one every locked cycle.

Only the bench scenarios can show the following:
- the bit values themselves, which depend on polarity and pattern;
- that a preamble mismatch restarts the count;
- that boundary transitions are rejected;
- the different outcomes of a stretched bit period with drift mode on and off.

// File: rtl/manch_rx_pkg.sv
// Shared types for the Manchester receiver.
// Assumes pattern codes are two bits wide and alternating patterns are
// indexed by the position of the bit inside the preamble.
package manch_rx_pkg;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_PRE  = 2'd1,
        ST_DATA = 2'd2
    } rx_state_e;

    typedef enum logic [1:0] {
        PAT_ONES  = 2'b00,
        PAT_ZEROS = 2'b01,
        PAT_ZO    = 2'b10,
        PAT_OZ    = 2'b11
    } pat_e;

    // Expected polarity-0 bit of the preamble at an even or odd position.
    function automatic logic pat_bit(input logic [1:0] sel, input logic odd);
        logic r;
        case (pat_e'(sel))
            PAT_ONES:  r = 1'b1;
            PAT_ZEROS: r = 1'b0;
            PAT_ZO:    r = odd;
            default:   r = ~odd;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mrx_line_sync.sv
// Brings the raw line into the clock domain and flags its transitions.
// Assumes: the line is asynchronous. The stages carry no reset, so that a
// line parked at 1 does not appear as a transition when reset is released.
module mrx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic line_in,
    output logic rise,
    output logic fall
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_q;

    // The first stage samples the raw line.
    always_ff @(posedge clk) begin
        pipe_q[0] <= line_in;
    end

    // The remaining stages shift; the last one holds the previous value.
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            pipe_q[g] <= pipe_q[g-1];
        end
    end

    // Transition flags, from the last synchronised value and the one before.
    always_comb begin
        rise = pipe_q[DEPTH-2] & ~pipe_q[DEPTH-1];
        fall = ~pipe_q[DEPTH-2] & pipe_q[DEPTH-1];
    end

endmodule

// File: rtl/mrx_bit_timer.sv
// Half-bit timing. A phase counter is 0 at the expected bit centre, and
// a window of +/-WIN clocks around it accepts one transition per bit. The
// captured bit is reported at once. A window that closes empty is a miss.
// Assumes: WIN < OSR/2, so the window never reaches a bit boundary.
module mrx_bit_timer #(
    parameter int OSR = 16,
    parameter int WIN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hunting,
    input  logic                     drift_en,
    input  logic                     rise,
    input  logic                     fall,
    output logic [$clog2(OSR)-1:0]   ph_o,
    output logic                     bit_rdy,
    output logic                     bit_raw,
    output logic                     miss
);
    localparam int PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_LAST  = PH_W'(OSR - 1);
    localparam logic [PH_W-1:0] PH_OPEN  = PH_W'(OSR - WIN);
    localparam logic [PH_W-1:0] PH_CLOSE = PH_W'(WIN);
    localparam logic [PH_W-1:0] PH_ONE   = PH_W'(1);

    logic [PH_W-1:0] ph_q, ph_inc;
    logic            got_q;
    logic            edge_any, in_win, at_close, cap;

    // Decode the window position and decide whether this clock captures a bit.
    always_comb begin
        edge_any = rise | fall;
        ph_inc   = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        in_win   = (ph_q >= PH_OPEN) || (ph_q <= PH_CLOSE);
        at_close = !hunting && (ph_q == PH_CLOSE);
        cap      = !hunting && edge_any && in_win && !got_q;
        bit_rdy  = (hunting && edge_any) || cap;
        bit_raw  = fall;
        miss     = at_close && !got_q && !cap;
        ph_o     = ph_q;
    end

    // Phase counter, and the flag saying this window has already taken its bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= '0;
            got_q <= 1'b0;
        end else if (hunting) begin
            if (edge_any) begin
                ph_q  <= PH_ONE;
                got_q <= 1'b1;
            end else begin
                got_q <= 1'b0;
            end
        end else begin
            ph_q <= (cap && drift_en) ? PH_ONE : ph_inc;
            if (at_close) begin
                got_q <= cap && drift_en;
            end else if (cap) begin
                got_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/mrx_preamble.sv
// Counts consecutive preamble bits that match the selected pattern.
// Assumes: pre_len is nonzero whenever step is raised, and it is held
// steady while a frame is being received.
module mrx_preamble
    import manch_rx_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic             raw,
    input  logic [1:0]       pat_sel,
    input  logic [LEN_W-1:0] pre_len,
    output logic             done
);
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W:0]   cnt_next;
    logic             match;

    // Compare the incoming bit with the pattern, and detect the final match.
    always_comb begin
        match    = (raw == pat_bit(pat_sel, cnt_q[0]));
        cnt_next = {1'b0, cnt_q} + (LEN_W+1)'(1);
        done     = step && match && (cnt_next == {1'b0, pre_len});
    end

    // Match counter: cleared on a miss, a mismatch or completion.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (match && !done) ? cnt_next[LEN_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/mrx_deser.sv
// Packs data bits into words, least significant bit first, and strobes
// each completed word for one clock.
// Assumes: the bit counter is zero whenever the data phase begins.
module mrx_deser #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    input  logic              din,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o
);
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] shift_nx;
    logic [CNT_W-1:0]  cnt_q;

    // Next value of the shift register, with the new bit entering at the top.
    always_comb begin
        shift_nx = {din, shift_q[DATA_W-1:1]};
    end

    // Shift register and bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            shift_q <= '0;
            cnt_q   <= '0;
        end else if (step) begin
            shift_q <= shift_nx;
            cnt_q   <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // Output register and its one-clock strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= step && !restart && (cnt_q == CNT_LAST);
            if (step && !restart && (cnt_q == CNT_LAST)) begin
                data_o <= shift_nx;
            end
        end
    end

endmodule

// File: rtl/manch_rx.sv
// Manchester receiver top level. Sequence: wait for a lock transition,
// match the preamble, then decode data until a bit window is missed.
// Assumes: the configuration inputs are static during a frame, and the
// clock is OSR times the bit rate.
module manch_rx
    import manch_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int WIN         = 4,
    parameter int DATA_W      = 8,
    parameter int LEN_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              rx_pol,
    input  logic [1:0]        pat_sel,
    input  logic [LEN_W-1:0]  pre_len,
    input  logic              drift_en,
    output logic [DATA_W-1:0] data_out,
    output logic              data_valid,
    output logic              code_err
);
    localparam int PH_W = $clog2(OSR);

    rx_state_e       state_q, state_eff, state_nx;
    logic            rise, fall;
    logic            hunting, in_data;
    logic [PH_W-1:0] ph_cnt;
    logic            bit_rdy, bit_raw, miss;
    logic            pre_step, data_step, pre_done;
    logic            err_q;

    mrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .line_in (line_in),
        .rise    (rise),
        .fall    (fall)
    );

    mrx_bit_timer #(.OSR(OSR), .WIN(WIN)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .hunting  (hunting),
        .drift_en (drift_en),
        .rise     (rise),
        .fall     (fall),
        .ph_o     (ph_cnt),
        .bit_rdy  (bit_rdy),
        .bit_raw  (bit_raw),
        .miss     (miss)
    );

    // Route each bit by state. The lock bit already belongs to the next phase.
    always_comb begin
        hunting   = (state_q == ST_HUNT);
        in_data   = (state_q == ST_DATA);
        state_eff = state_q;
        if (hunting) begin
            state_eff = (pre_len == '0) ? ST_DATA : ST_PRE;
        end
        pre_step  = bit_rdy && (state_eff == ST_PRE);
        data_step = bit_rdy && (state_eff == ST_DATA);
    end

    mrx_preamble #(.LEN_W(LEN_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (miss),
        .step    (pre_step),
        .raw     (bit_raw),
        .pat_sel (pat_sel),
        .pre_len (pre_len),
        .done    (pre_done)
    );

    mrx_deser #(.DATA_W(DATA_W)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (miss),
        .step    (data_step),
        .din     (bit_raw ^ rx_pol),
        .data_o  (data_out),
        .valid_o (data_valid)
    );

    // Next-state decision for the receive sequence.
    always_comb begin
        state_nx = state_q;
        if (miss) begin
            state_nx = ST_HUNT;
        end else if (bit_rdy) begin
            if (state_eff == ST_PRE) begin
                state_nx = pre_done ? ST_DATA : ST_PRE;
            end else begin
                state_nx = ST_DATA;
            end
        end
    end

    // State register and the registered error strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_nx;
            err_q   <= miss;
        end
    end

    assign code_err = err_q;

endmodule

// File: rtl/manch_rx_chk.sv
// Property checker for manch_rx. It is attached by the bind statement at
// the end of this file and reads the top-level outputs, the state flags and
// the phase counter.
module manch_rx_chk #(
    parameter int OSR = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   drift_en,
    input logic                   data_valid,
    input logic                   code_err,
    input logic                   hunting,
    input logic                   in_data,
    input logic [$clog2(OSR)-1:0] ph
);
    localparam int PH_W = $clog2(OSR);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

    AST_VALID_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);                                           // R2

    AST_VALID_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> in_data);                                               // R2

    AST_ERR_RETURNS_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> hunting);                                                 // R6

    AST_ERR_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        code_err |-> $past(!hunting));                                         // R6

    AST_ERR_NOT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_err && data_valid));                                            // R6

    AST_FIXED_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!hunting) && $past(!drift_en)) |->
            (ph == (($past(ph) == PH_LAST) ? '0 : $past(ph) + 1'b1)));          // R7

endmodule

bind manch_rx manch_rx_chk #(.OSR(OSR)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .drift_en   (drift_en),
    .data_valid (data_valid),
    .code_err   (code_err),
    .hunting    (hunting),
    .in_data    (in_data),
    .ph         (ph_cnt)
);

// File: tb/tb_manch_rx.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_manch_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_in = 1'b0;
    logic       rx_pol = 1'b1;
    logic [1:0] pat_sel = 2'b00;
    logic [3:0] pre_len = 4'd1;
    logic       drift_en = 1'b0;
    logic [7:0] data_out;
    logic       data_valid;
    logic       code_err;

    int n_chk = 0;
    int n_bad = 0;
    int n_val = 0;
    int n_err = 0;
    logic [7:0] rx_b [0:7];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    manch_rx dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .rx_pol     (rx_pol),
        .pat_sel    (pat_sel),
        .pre_len    (pre_len),
        .drift_en   (drift_en),
        .data_out   (data_out),
        .data_valid (data_valid),
        .code_err   (code_err)
    );

    // Record strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (data_valid) begin
                if (n_val < 8) rx_b[n_val] = data_out;
                n_val++;
            end
            if (code_err) n_err++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic start(input logic pol, input logic [1:0] pat, input logic [3:0] len,
                         input logic drift, input logic lvl);
        rst_n    = 1'b0;
        rx_pol   = pol;
        pat_sel  = pat;
        pre_len  = len;
        drift_en = drift;
        line_in  = lvl;
        n_val    = 0;
        n_err    = 0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_raw(input logic raw, input int h1, input int h2);
        line_in = raw;
        repeat (h1) @(negedge clk);
        line_in = ~raw;
        repeat (h2) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic pol, input int h1, input int h2);
        for (int i = 0; i < 8; i++) send_raw(d[i] ^ pol, h1, h2);
    endtask

    task automatic t_reset();
        start(1'b1, 2'b00, 4'd1, 1'b0, 1'b1);
        @(negedge clk);
        chk("R10 valid low after reset", int'(data_valid), 0);
        chk("R10 error low after reset", int'(code_err), 0);
        repeat (100) @(negedge clk);
        chk("R10 quiet line bytes", n_val, 0);
        chk("R10 quiet line errors", n_err, 0);
    endtask

    task automatic t_defaults();
        start(1'b1, 2'b00, 4'd1, 1'b0, 1'b1);
        send_raw(1'b1, 8, 8);
        send_byte(8'hA5, 1'b1, 8, 8);
        repeat (60) @(negedge clk);
        chk("R1 pol1 byte count", n_val, 1);
        chk("R1 pol1 byte value", int'(rx_b[0]), 'hA5);
        chk("R6 error at frame end", n_err, 1);
    endtask

    task automatic t_no_preamble();
        start(1'b0, 2'b00, 4'd0, 1'b0, 1'b0);
        send_byte(8'h3C, 1'b0, 8, 8);
        send_byte(8'hC3, 1'b0, 8, 8);
        repeat (60) @(negedge clk);
        chk("R3 byte count", n_val, 2);
        chk("R3 first byte", int'(rx_b[0]), 'h3C);
        chk("R2 second byte", int'(rx_b[1]), 'hC3);
    endtask

    task automatic t_one_zero();
        start(1'b0, 2'b11, 4'd4, 1'b0, 1'b1);
        send_raw(1'b1, 8, 8); send_raw(1'b0, 8, 8);
        send_raw(1'b1, 8, 8); send_raw(1'b0, 8, 8);
        send_byte(8'h96, 1'b0, 8, 8);
        repeat (60) @(negedge clk);
        chk("R4 one-zero byte count", n_val, 1);
        chk("R4 one-zero byte", int'(rx_b[0]), 'h96);
    endtask

    task automatic t_zero_one_pol1();
        start(1'b1, 2'b10, 4'd3, 1'b0, 1'b0);
        send_raw(1'b0, 8, 8); send_raw(1'b1, 8, 8); send_raw(1'b0, 8, 8);
        send_byte(8'h5A, 1'b1, 8, 8);
        repeat (60) @(negedge clk);
        chk("R4 zero-one byte count", n_val, 1);
        chk("R4 zero-one byte pol1", int'(rx_b[0]), 'h5A);
    endtask

    task automatic t_mismatch();
        start(1'b0, 2'b01, 4'd2, 1'b0, 1'b0);
        send_raw(1'b0, 8, 8); send_raw(1'b1, 8, 8);
        send_raw(1'b0, 8, 8); send_raw(1'b0, 8, 8);
        send_byte(8'h81, 1'b0, 8, 8);
        repeat (60) @(negedge clk);
        chk("R5 byte count after restart", n_val, 1);
        chk("R5 byte after restart", int'(rx_b[0]), 'h81);
    endtask

    task automatic t_missing();
        start(1'b0, 2'b00, 4'd1, 1'b0, 1'b1);
        send_raw(1'b1, 8, 8);
        send_raw(1'b1, 8, 8); send_raw(1'b1, 8, 8); send_raw(1'b0, 8, 8);
        repeat (60) @(negedge clk);
        chk("R6 no byte on missed window", n_val, 0);
        chk("R6 one error pulse", n_err, 1);
    endtask

    task automatic t_drift_off();
        start(1'b0, 2'b10, 4'd1, 1'b0, 1'b0);
        send_raw(1'b0, 9, 9);
        send_byte(8'h55, 1'b0, 9, 9);
        repeat (60) @(negedge clk);
        chk("R7 no byte with slow sender", n_val, 0);
        chk("R7 error seen", int'(n_err != 0), 1);
    endtask

    task automatic t_drift_on();
        start(1'b0, 2'b10, 4'd1, 1'b1, 1'b0);
        send_raw(1'b0, 9, 9);
        send_byte(8'h55, 1'b0, 9, 9);
        repeat (60) @(negedge clk);
        chk("R8 byte count slow sender", n_val, 1);
        chk("R8 byte slow sender", int'(rx_b[0]), 'h55);
        chk("R8 single end error", n_err, 1);
    endtask

    task automatic t_boundaries();
        start(1'b0, 2'b00, 4'd2, 1'b1, 1'b1);
        send_raw(1'b1, 8, 8); send_raw(1'b1, 8, 8);
        send_byte(8'hF0, 1'b0, 8, 8);
        send_byte(8'h00, 1'b0, 8, 8);
        repeat (60) @(negedge clk);
        chk("R9 byte count", n_val, 2);
        chk("R9 byte F0", int'(rx_b[0]), 'hF0);
        chk("R9 byte 00", int'(rx_b[1]), 'h00);
    endtask

    initial begin
        t_reset();
        t_defaults();
        t_no_preamble();
        t_one_zero();
        t_zero_one_pol1();
        t_mismatch();
        t_missing();
        t_drift_off();
        t_drift_on();
        t_boundaries();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule